// File: doc/BRIEF.md
# Overcurrent Hiccup Fault Manager

This block supervises the power stage of a switching regulator. It watches the high-side current-limit flag once per switching period. Every period that hits the limit adds one to a small fault tally. Every period whose high-side pulse finishes cleanly counts towards a clearing run. When the tally overflows, the block enters a hiccup: it gates both switches off and keeps the soft-start capacitor discharged for a fixed number of switching periods. At the end of that wait it issues a one-cycle restart request, and a new soft-start begins.

An over-temperature flag also gates switching off and holds soft-start discharged. Switching resumes through the same restart request once the flag drops; the sensor's own hysteresis decides when that is. The protection is armed from the first period after any restart, so a short circuit that persists through soft-start trips again. When the enable input is low, the block sits in an off state with every counter and timer cleared.

The power stage is expected to report events as follows:
- `hs_on` pulses when a high-side pulse begins.
- `ilim` pulses when the current limit ends that pulse.
- `sw_tick` marks the last clock of each switching period.

Top module: `hiccup_fault_mgr`

## Requirements
- R1: During reset and until enable is first seen high, `gate_off` and `ss_dis` are 1 and `restart` is 0.
- R2: While the block is off, a clock edge that sees `en` high with `ot_flag` low moves it to running. `gate_off` falls and `restart` is 1 from that edge on.
- R3: A switching period whose window (the clocks up to and including its `sw_tick` clock) contains an `ilim` pulse adds one to the fault tally and breaks any clean run.
- R4: A tally of any size is cleared by three consecutive periods that contain an `hs_on` pulse and no `ilim` pulse. Periods with neither pulse leave the tally and the clean run unchanged.
- R5: The period that brings the tally to eight (the 3-bit counter overflowing) raises `gate_off` and `ss_dis` at the edge that ends it.
- R6: A hiccup lasts exactly 1024 `sw_tick` clocks. The edge that takes the 1024th drops `gate_off` and `ss_dis` and raises `restart`.
- R7: The tally starts from zero and counts from the first period after a restart, so eight faults during soft-start trip a new hiccup.
- R8: `ot_flag` high in any enabled state raises `gate_off` at the next edge and clears the tally and the hiccup timer. The first edge that sees it low releases switching with a `restart` pulse.
- R9: `en` low forces the off state at the next edge and clears the tally, the clean run and the hiccup timer.
- R10: `hs_on` and `ilim` pulses that arrive while the block is off, in hiccup or in thermal shutdown are ignored.
- R11: `restart` is never high on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Regulator enable |
| sw_tick | input | 1 | Last clock of a switching period |
| hs_on | input | 1 | High-side pulse began |
| ilim | input | 1 | High-side current limit reached |
| ot_flag | input | 1 | Die over-temperature, hysteresis applied upstream |
| gate_off | output | 1 | Hold both power switches off |
| ss_dis | output | 1 | Discharge the soft-start capacitor |
| restart | output | 1 | One-cycle request to begin soft-start |

## Verification
The bench builds the block with its default parameters:
- a 3-bit tally;
- a clean run of three;
- a wait of 1024 periods.

The switching tick comes every third clock, so one full hiccup fits in a few thousand cycles. The bench can therefore measure the wait length tick by tick, and still run the tally to its overflow several times in one run. These values also place the limits of the clean run, the overflow and the timer's final count inside the scenarios. That brings into reach the interplay of faults landing during a hiccup, thermal entry during a hiccup, and enable drops with a partly filled tally.

// File: rtl/hfm_pkg.sv
package hfm_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_RUN    = 2'd1,
        ST_HICCUP = 2'd2,
        ST_THERM  = 2'd3
    } hfm_state_e;
endpackage

// File: rtl/hfm_fault_tally.sv
module hfm_fault_tally #(
    parameter int CNT_W     = 3,
    parameter int CLEAN_RUN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic sw_tick,
    input  logic hs_on,
    input  logic ilim,
    output logic trip
);
    localparam int CLEAN_W = $clog2(CLEAN_RUN + 1);
    localparam logic [CNT_W-1:0]   FAULT_TOP  = {CNT_W{1'b1}};
    localparam logic [CLEAN_W-1:0] CLEAN_LAST = CLEAN_W'(CLEAN_RUN - 1);

    typedef struct packed {
        logic [CNT_W-1:0]   faults;
        logic [CLEAN_W-1:0] clean;
        logic               hs_seen;
        logic               il_seen;
    } tally_s;

    tally_s q, d;
    logic hs_now, il_now;

    always_comb begin
        d      = q;
        trip   = 1'b0;
        hs_now = q.hs_seen | hs_on;
        il_now = q.il_seen | ilim;
        if (!active) begin
            d = '0;
        end else if (sw_tick) begin
            d.hs_seen = 1'b0;
            d.il_seen = 1'b0;
            if (il_now) begin
                d.clean = '0;
                if (q.faults == FAULT_TOP) begin
                    trip     = 1'b1;
                    d.faults = '0;
                end else begin
                    d.faults = q.faults + 1'b1;
                end
            end else if (hs_now) begin
                if (q.clean == CLEAN_LAST) begin
                    d.clean  = '0;
                    d.faults = '0;
                end else begin
                    d.clean = q.clean + 1'b1;
                end
            end
        end else begin
            d.hs_seen = hs_now;
            d.il_seen = il_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R9: an inactive tally holds nothing into the next cycle
    p_idle_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (q.faults == '0 && q.clean == '0));

    // R3: a faulted period below the top adds exactly one
    p_fault_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && sw_tick && (q.il_seen || ilim) && q.faults != FAULT_TOP)
        |=> q.faults == $past(q.faults) + 1'b1);
endmodule

// File: rtl/hfm_hiccup_timer.sv
module hfm_hiccup_timer #(
    parameter int WAIT_TICKS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic sw_tick,
    output logic done
);
    localparam int TMR_W = (WAIT_TICKS > 2) ? $clog2(WAIT_TICKS) : 1;
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(WAIT_TICKS - 1);

    typedef struct packed {
        logic [TMR_W-1:0] cnt;
    } timer_s;

    timer_s q, d;

    always_comb begin
        d    = q;
        done = 1'b0;
        if (!active) begin
            d.cnt = '0;
        end else if (sw_tick) begin
            if (q.cnt == TMR_LAST) begin
                done  = 1'b1;
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R6: the wait advances on switching ticks only
    p_hold_between_ticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !sw_tick) |=> $stable(q.cnt));

    // R9: an idle timer restarts from zero
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> q.cnt == '0);
endmodule

// File: rtl/hiccup_fault_mgr.sv
module hiccup_fault_mgr
    import hfm_pkg::*;
#(
    parameter int CNT_W      = 3,
    parameter int CLEAN_RUN  = 3,
    parameter int WAIT_TICKS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sw_tick,
    input  logic hs_on,
    input  logic ilim,
    input  logic ot_flag,
    output logic gate_off,
    output logic ss_dis,
    output logic restart
);
    typedef struct packed {
        hfm_state_e st;
        logic       restart;
    } ctl_s;

    ctl_s q, d;
    logic tally_act, timer_act, trip, done;

    assign tally_act = en && !ot_flag && (q.st == ST_RUN);
    assign timer_act = en && !ot_flag && (q.st == ST_HICCUP);

    hfm_fault_tally #(
        .CNT_W     (CNT_W),
        .CLEAN_RUN (CLEAN_RUN)
    ) u_tally (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (tally_act),
        .sw_tick (sw_tick),
        .hs_on   (hs_on),
        .ilim    (ilim),
        .trip    (trip)
    );

    hfm_hiccup_timer #(
        .WAIT_TICKS (WAIT_TICKS)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (timer_act),
        .sw_tick (sw_tick),
        .done    (done)
    );

    always_comb begin
        d         = q;
        d.restart = 1'b0;
        if (!en) begin
            d.st = ST_OFF;
        end else begin
            case (q.st)
                ST_OFF: begin
                    if (ot_flag) begin
                        d.st = ST_THERM;
                    end else begin
                        d.st      = ST_RUN;
                        d.restart = 1'b1;
                    end
                end
                ST_RUN: begin
                    if (ot_flag)   d.st = ST_THERM;
                    else if (trip) d.st = ST_HICCUP;
                end
                ST_HICCUP: begin
                    if (ot_flag) begin
                        d.st = ST_THERM;
                    end else if (done) begin
                        d.st      = ST_RUN;
                        d.restart = 1'b1;
                    end
                end
                default: begin
                    if (!ot_flag) begin
                        d.st      = ST_RUN;
                        d.restart = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= ST_OFF;
            q.restart <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign gate_off = (q.st != ST_RUN);
    assign ss_dis   = (q.st != ST_RUN);
    assign restart  = q.restart;

    // R11
    p_restart_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !restart);

    // R6: a restart always coincides with switching released
    p_restart_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> !gate_off);

    // R9
    p_disable_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (gate_off && ss_dis && !restart));

    // R5
    p_trip_hiccup_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (trip && en && !ot_flag) |=> (gate_off && ss_dis));

    // R6
    p_done_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && en && !ot_flag) |=> restart);

    // R8
    p_therm_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ot_flag) |=> (gate_off && !restart));
endmodule

// File: tb/test_hiccup_fault_mgr.sv
module test_hiccup_fault_mgr;
    localparam int WAIT = 1024;

    logic clk = 1'b0, rst_n = 1'b0;
    logic en = 1'b0, sw_tick = 1'b0, hs_on = 1'b0, ilim = 1'b0, ot_flag = 1'b0;
    logic gate_off, ss_dis, restart;

    int n_chk = 0, n_bad = 0;
    string cur_req = "R1";

    // reference model state: 0 off, 1 run, 2 hiccup, 3 thermal
    int m_st = 0, m_fault = 0, m_clean = 0, m_tmr = 0;
    bit m_hs = 0, m_il = 0, m_rs = 0;

    always #2.5 clk = ~clk;

    hiccup_fault_mgr i_hiccup_fault_mgr (
        .clk(clk), .rst_n(rst_n), .en(en), .sw_tick(sw_tick), .hs_on(hs_on),
        .ilim(ilim), .ot_flag(ot_flag), .gate_off(gate_off), .ss_dis(ss_dis),
        .restart(restart)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic m_clear();
        m_fault = 0; m_clean = 0; m_hs = 0; m_il = 0;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_tmr = 0; m_rs = 0; m_clear();
        end else begin
            bit hsn, iln;
            m_rs = 0;
            if (!en) begin
                m_st = 0; m_tmr = 0; m_clear();
            end else if (m_st == 0) begin
                m_clear(); m_tmr = 0;
                if (ot_flag) m_st = 3; else begin m_st = 1; m_rs = 1; end
            end else if (m_st == 1) begin
                m_tmr = 0;
                if (ot_flag) begin
                    m_st = 3; m_clear();
                end else begin
                    hsn = m_hs || hs_on;
                    iln = m_il || ilim;
                    if (sw_tick) begin
                        m_hs = 0; m_il = 0;
                        if (iln) begin
                            m_clean = 0;
                            if (m_fault == 7) begin m_fault = 0; m_st = 2; end
                            else m_fault++;
                        end else if (hsn) begin
                            if (m_clean == 2) begin m_clean = 0; m_fault = 0; end
                            else m_clean++;
                        end
                    end else begin
                        m_hs = hsn; m_il = iln;
                    end
                end
            end else if (m_st == 2) begin
                m_clear();
                if (ot_flag) begin m_st = 3; m_tmr = 0; end
                else if (sw_tick) begin
                    if (m_tmr == WAIT - 1) begin m_st = 1; m_rs = 1; m_tmr = 0; end
                    else m_tmr++;
                end
            end else begin
                m_clear(); m_tmr = 0;
                if (!ot_flag) begin m_st = 1; m_rs = 1; end
            end
        end
    end

    // per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk({cur_req, " gate_off"}, gate_off, logic'(m_st != 1));
            chk({cur_req, " ss_dis"},   ss_dis,   logic'(m_st != 1));
            chk({cur_req, " restart"},  restart,  logic'(m_rs));
        end
    end

    task automatic sw_cycle(input bit pulse, input bit lim);
        hs_on = pulse; @(negedge clk);
        hs_on = 1'b0; ilim = lim; @(negedge clk);
        ilim = 1'b0; sw_tick = 1'b1; @(negedge clk);
        sw_tick = 1'b0;
    endtask

    task automatic faults(input int n);
        for (int i = 0; i < n; i++) sw_cycle(1'b1, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got hang expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 gate_off", gate_off, 1'b1);
        chk("R1 ss_dis", ss_dis, 1'b1);
        chk("R1 restart", restart, 1'b0);

        cur_req = "R2"; en = 1'b1; @(negedge clk);
        chk("R2 restart", restart, 1'b1);
        chk("R2 gate_off", gate_off, 1'b0);
        @(negedge clk);
        chk("R11 restart", restart, 1'b0);

        // R4: partial tally cleared by three clean pulses, idle period in between
        cur_req = "R4";
        faults(5);
        sw_cycle(1'b1, 1'b0); sw_cycle(1'b1, 1'b0);
        sw_cycle(1'b0, 1'b0);
        sw_cycle(1'b1, 1'b0);
        faults(7);
        chk("R4 gate_off after 7", gate_off, 1'b0);
        // R3: a clean run broken by a fault does not clear
        cur_req = "R3";
        sw_cycle(1'b1, 1'b0); sw_cycle(1'b1, 1'b0);
        cur_req = "R5";
        faults(1);
        chk("R5 gate_off", gate_off, 1'b1);
        chk("R5 ss_dis", ss_dis, 1'b1);

        // R6 and R10: measure the wait with faults arriving meanwhile
        cur_req = "R6"; n = 0;
        forever begin
            sw_tick = 1'b1; @(negedge clk); sw_tick = 1'b0; n++;
            if (restart || n > 3000) break;
            hs_on = 1'b1; ilim = 1'b1; @(negedge clk);
            hs_on = 1'b0; ilim = 1'b0; @(negedge clk);
        end
        chk("R6 wait length", logic'(n == WAIT), 1'b1);
        chk("R6 gate_off", gate_off, 1'b0);

        cur_req = "R10";
        faults(7);
        chk("R10 gate_off", gate_off, 1'b0);
        cur_req = "R7";
        faults(1);
        chk("R7 gate_off", gate_off, 1'b1);

        // R8: over-temperature during hiccup, then release
        cur_req = "R8";
        repeat (5) sw_cycle(1'b0, 1'b0);
        ot_flag = 1'b1;
        repeat (4) sw_cycle(1'b1, 1'b1);
        chk("R8 gate_off", gate_off, 1'b1);
        chk("R8 restart", restart, 1'b0);
        ot_flag = 1'b0; @(negedge clk);
        chk("R8 restart", restart, 1'b1);
        // R8: over-temperature while running clears the tally
        faults(5);
        ot_flag = 1'b1; @(negedge clk); @(negedge clk);
        chk("R8 gate_off run", gate_off, 1'b1);
        ot_flag = 1'b0; @(negedge clk);
        faults(7);
        chk("R8 tally cleared", gate_off, 1'b0);

        // R9: enable drop clears the tally
        cur_req = "R9";
        en = 1'b0; @(negedge clk);
        chk("R9 gate_off", gate_off, 1'b1);
        chk("R9 ss_dis", ss_dis, 1'b1);
        faults(3);
        en = 1'b1; @(negedge clk);
        chk("R2 restart again", restart, 1'b1);
        faults(7);
        chk("R9 tally cleared", gate_off, 1'b0);
        faults(1);
        chk("R5 second trip", gate_off, 1'b1);
        repeat (4) @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule